// File: doc/BRIEF.md
# DDR SDRAM Command Front-End with Bank State

This block sits on the controller side of a DDR SDRAM command bus. On every rising clock edge it samples the active-low chip select and the RAS/CAS/WE strobes, the bank address and the multiplexed address bus. It turns these into one decoded operation. The result comes out on registered outputs one cycle later, together with the row or column part of the address that belongs to that operation.

The block also keeps a record of each of the four banks: whether the bank is open and which row it holds. It applies the dual role of address bit 10. On a read or write, bit 10 schedules a delayed close of the bank. On a precharge, bit 10 chooses between closing every bank and closing only the addressed bank.

Clock enable drives entry into power-down or self-refresh and holds off decoding while it is low. Misuse is reported on two error flags, and the block still decodes the command. Those misuses are a column access to a closed bank, an activate of an open bank, and a refresh while a bank is open.

Top module: `sdr_cmd_front`

## Requirements
- R1: Inputs are sampled only on the rising clock edge, and the decoded result appears on the registered outputs after that edge. Input strobes {ras_n,cas_n,we_n} decode as follows: 111 NOP, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop. The `op` output codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, MRS=6, BST=7.
- R2: With cs_n high, `op` reports NOP and no bank state changes because of that cycle. An auto-precharge already scheduled still closes its bank on time.
- R3: An activate opens the bank given by `ba` and stores addr[12:0] as its row. The row appears on `op_row` and in the 13-bit field of `open_rows` at bit position 13*bank.
- R4: A read or write reports addr[9:0] on `op_col` and addr[10] on `auto_pre`.
- R5: A read or write with addr[10] high to an open bank closes that bank exactly BURST (default 4) clock edges after the edge that accepted the command. With addr[10] low the bank stays open.
- R6: A precharge with addr[10] high closes all banks whatever `ba` holds, and `pre_all` is set. With addr[10] low only bank `ba` closes.
- R7: When cke is sampled low, `pwr_down` is set and `op` is NOP. Commands are ignored while cke stays low. When cke is sampled high, the low-power state is left and decoding resumes.
- R8: If cke is first sampled low together with a refresh command (cs_n low), `self_ref` is set instead of `pwr_down`. The two are never set together.
- R9: `seq_err` pulses for a read or write to a closed bank, or for an activate of an open bank. The command is still decoded and applied.
- R10: `ref_err` pulses for a refresh, or a self-refresh entry, while any bank is open.
- R11: A low `rst_n` clears every registered output and closes all banks at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, low requests a low-power state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Multiplexed row / column address, bit 10 is the precharge control |
| op | output | 3 | Decoded operation code |
| op_bank | output | 2 | Bank of the decoded operation |
| op_row | output | 13 | Row address of an activate |
| op_col | output | 10 | Column address of a read or write |
| auto_pre | output | 1 | Read/write carried auto-precharge |
| pre_all | output | 1 | Precharge targeted all banks |
| seq_err | output | 1 | Bank-state misuse by activate/read/write |
| ref_err | output | 1 | Refresh with a bank open |
| pwr_down | output | 1 | In power-down |
| self_ref | output | 1 | In self-refresh |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Open row per bank, 13 bits each |

## Verification
A vector table walks all eight strobe codes. It covers an activate repeated on an open bank and a read to a bank that was never opened, which separates correct decoding from correct state checking. It drives a deselected activate, which separates chip-select gating from decoding. It issues single-bank and all-bank precharges, which tell the two roles of bit 10 apart. Directed sequences then time the auto-precharge close edge by edge while chip select is high. They compare a plain cke drop with a cke drop carrying refresh, check that commands are ignored in power-down, and apply reset between clock edges.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_MRS = 3'd6,
        OP_BST = 3'd7
    } op_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output op_e  op,
    output logic ref_req
);
    op_e raw;

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b111:  raw = OP_NOP;
            3'b011:  raw = OP_ACT;
            3'b101:  raw = OP_RD;
            3'b100:  raw = OP_WR;
            3'b010:  raw = OP_PRE;
            3'b001:  raw = OP_REF;
            3'b000:  raw = OP_MRS;
            default: raw = OP_BST;
        endcase
        // refresh request seen regardless of cke, used for self-refresh entry
        ref_req = !cs_n && (raw == OP_REF);
        op      = (!cs_n && cke) ? raw : OP_NOP;
    end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
    parameter  int NBANK = 4,
    parameter  int ROW_W = 13,
    parameter  int BURST = 4,
    localparam int BA_W  = $clog2(NBANK),
    localparam int CNT_W = $clog2(BURST + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_en,
    input  logic                   pre_en,
    input  logic                   pre_all,
    input  logic                   ap_en,
    input  logic [BA_W-1:0]        bank,
    input  logic [ROW_W-1:0]       row,
    output logic [NBANK-1:0]       open,
    output logic [NBANK*ROW_W-1:0] rows
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } bank_s;

    bank_s [NBANK-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NBANK; i++) begin
            // pending auto-precharge runs on regardless of the current command
            if (st_q[i].cnt != '0) begin
                st_d[i].cnt = st_q[i].cnt - CNT_W'(1);
                if (st_q[i].cnt == CNT_W'(1)) st_d[i].open = 1'b0;
            end
            if (pre_en && (pre_all || bank == BA_W'(i))) begin
                st_d[i].open = 1'b0;
                st_d[i].cnt  = '0;
            end
            if (act_en && bank == BA_W'(i)) begin
                st_d[i].open = 1'b1;
                st_d[i].row  = row;
                st_d[i].cnt  = '0;
            end
            if (ap_en && bank == BA_W'(i)) st_d[i].cnt = CNT_W'(BURST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_out
        assign open[g]                  = st_q[g].open;
        assign rows[g*ROW_W +: ROW_W]   = st_q[g].row;
    end

    a_r6_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && pre_all) |=> (open == '0));
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> open[$past(bank)]);
    a_r5_ap_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_en && !pre_en) |=> open[$past(bank)]);
endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
    import sdr_cmd_pkg::*;
#(
    parameter  int NBANK  = 4,
    parameter  int ROW_W  = 13,
    parameter  int COL_W  = 10,
    parameter  int AP_BIT = 10,
    parameter  int BURST  = 4,
    localparam int BA_W   = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       addr,
    output logic [2:0]             op,
    output logic [BA_W-1:0]        op_bank,
    output logic [ROW_W-1:0]       op_row,
    output logic [COL_W-1:0]       op_col,
    output logic                   auto_pre,
    output logic                   pre_all,
    output logic                   seq_err,
    output logic                   ref_err,
    output logic                   pwr_down,
    output logic                   self_ref,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] open_rows
);
    typedef struct packed {
        op_e              op;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             ap;
        logic             pa;
        logic             serr;
        logic             rerr;
        logic             pd;
        logic             sr;
    } out_s;

    out_s o_d, o_q;
    op_e  dop;
    logic ref_req;
    logic act_en, pre_en, ap_en;

    sdr_cmd_decode u_dec (
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .op     (dop),
        .ref_req(ref_req)
    );

    always_comb begin
        act_en = (dop == OP_ACT);
        pre_en = (dop == OP_PRE);
        ap_en  = (dop == OP_RD || dop == OP_WR) && addr[AP_BIT] && bank_open[ba];

        o_d    = '0;
        o_d.pd = o_q.pd;
        o_d.sr = o_q.sr;
        if (!cke) begin
            if (!o_q.pd && !o_q.sr) begin
                if (ref_req) begin
                    o_d.sr   = 1'b1;
                    o_d.rerr = |bank_open;
                end else begin
                    o_d.pd = 1'b1;
                end
            end
        end else begin
            o_d.pd = 1'b0;
            o_d.sr = 1'b0;
        end

        o_d.op = dop;
        if (dop != OP_NOP) o_d.bank = ba;
        case (dop)
            OP_ACT: begin
                o_d.row  = addr;
                o_d.serr = bank_open[ba];
            end
            OP_RD, OP_WR: begin
                o_d.col  = addr[COL_W-1:0];
                o_d.ap   = addr[AP_BIT];
                o_d.serr = !bank_open[ba];
            end
            OP_PRE:  o_d.pa   = addr[AP_BIT];
            OP_REF:  o_d.rerr = |bank_open;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    sdr_bank_track #(.NBANK(NBANK), .ROW_W(ROW_W), .BURST(BURST)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_en (act_en),
        .pre_en (pre_en),
        .pre_all(addr[AP_BIT]),
        .ap_en  (ap_en),
        .bank   (ba),
        .row    (addr),
        .open   (bank_open),
        .rows   (open_rows)
    );

    assign op       = o_q.op;
    assign op_bank  = o_q.bank;
    assign op_row   = o_q.row;
    assign op_col   = o_q.col;
    assign auto_pre = o_q.ap;
    assign pre_all  = o_q.pa;
    assign seq_err  = o_q.serr;
    assign ref_err  = o_q.rerr;
    assign pwr_down = o_q.pd;
    assign self_ref = o_q.sr;

    a_r2_deselect_nop: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (op == 3'd0));
    a_r7_cke_low_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (op == 3'd0) && (pwr_down || self_ref));
    a_r8_lp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && self_ref));
    a_r9_read_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b101 && !bank_open[ba]) |=> seq_err);
    a_r10_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b001 && (bank_open != '0)) |=> ref_err);
endmodule

// File: tb/sim_sdr_cmd_front.sv
module sim_sdr_cmd_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [2:0]  op;
    logic [1:0]  op_bank;
    logic [12:0] op_row;
    logic [9:0]  op_col;
    logic        auto_pre, pre_all, seq_err, ref_err, pwr_down, self_ref;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    sdr_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .op(op),
        .op_bank(op_bank), .op_row(op_row), .op_col(op_col),
        .auto_pre(auto_pre), .pre_all(pre_all), .seq_err(seq_err),
        .ref_err(ref_err), .pwr_down(pwr_down), .self_ref(self_ref),
        .bank_open(bank_open), .open_rows(open_rows)
    );

    typedef struct packed {
        logic        cke;
        logic        cs_n;
        logic [2:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic [2:0]  e_op;
        logic [3:0]  e_open;
        logic        e_serr;
        logic        e_rerr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        {1'b1, 1'b0, 3'b111, 2'd0, 13'h0000, 3'd0, 4'b0000, 1'b0, 1'b0}, // R1 nop
        {1'b1, 1'b0, 3'b011, 2'd1, 13'h1ABC, 3'd1, 4'b0010, 1'b0, 1'b0}, // R3 act b1
        {1'b1, 1'b0, 3'b011, 2'd1, 13'h0005, 3'd1, 4'b0010, 1'b1, 1'b0}, // R9 act open
        {1'b1, 1'b0, 3'b101, 2'd2, 13'h0010, 3'd2, 4'b0010, 1'b1, 1'b0}, // R9 read closed
        {1'b1, 1'b0, 3'b100, 2'd1, 13'h0003, 3'd3, 4'b0010, 1'b0, 1'b0}, // R5 write no ap
        {1'b1, 1'b1, 3'b011, 2'd0, 13'h0000, 3'd0, 4'b0010, 1'b0, 1'b0}, // R2 deselected
        {1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 3'd7, 4'b0010, 1'b0, 1'b0}, // R1 burst stop
        {1'b1, 1'b0, 3'b011, 2'd3, 13'h0777, 3'd1, 4'b1010, 1'b0, 1'b0}, // R3 act b3
        {1'b1, 1'b0, 3'b010, 2'd1, 13'h0000, 3'd4, 4'b1000, 1'b0, 1'b0}, // R6 pre one
        {1'b1, 1'b0, 3'b000, 2'd0, 13'h0033, 3'd6, 4'b1000, 1'b0, 1'b0}, // R1 mrs
        {1'b1, 1'b0, 3'b010, 2'd0, 13'h0400, 3'd4, 4'b0000, 1'b0, 1'b0}, // R6 pre all
        {1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 3'd5, 4'b0000, 1'b0, 1'b0}, // R10 ref ok
        {1'b1, 1'b0, 3'b011, 2'd0, 13'h0100, 3'd1, 4'b0001, 1'b0, 1'b0}, // R3 act b0
        {1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 3'd5, 4'b0001, 1'b0, 1'b1}  // R10 ref open
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic k, input logic c, input logic [2:0] cmd,
                       input logic [1:0] b, input logic [12:0] a);
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = cmd; ba = b; addr = a;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset op", 64'(op), 64'd0);
        chk("R11 reset banks", 64'(bank_open), 64'd0);
        chk("R11 reset lp", 64'({pwr_down, self_ref}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].cke, VEC[i].cs_n, VEC[i].cmd, VEC[i].ba, VEC[i].addr);
            chk("R1 table op", 64'(op), 64'(VEC[i].e_op));
            chk("R6 table bank_open", 64'(bank_open), 64'(VEC[i].e_open));
            chk("R9 table seq_err", 64'(seq_err), 64'(VEC[i].e_serr));
            chk("R10 table ref_err", 64'(ref_err), 64'(VEC[i].e_rerr));
        end

        cyc(1, 0, 3'b010, 2'd2, 13'h0400);
        chk("R6 pre_all flag", 64'(pre_all), 64'd1);
        chk("R6 all closed", 64'(bank_open), 64'd0);

        cyc(1, 0, 3'b011, 2'd2, 13'h1F0F);
        chk("R3 op_row", 64'(op_row), 64'h1F0F);
        chk("R3 open_rows b2", 64'(open_rows[26 +: 13]), 64'h1F0F);
        chk("R3 op_bank", 64'(op_bank), 64'd2);

        cyc(1, 0, 3'b101, 2'd2, 13'h06A5);
        chk("R4 op_col", 64'(op_col), 64'h2A5);
        chk("R4 auto_pre", 64'(auto_pre), 64'd1);
        chk("R5 open after cmd", 64'(bank_open), 64'b0100);
        for (int k = 1; k <= 4; k++) begin
            cyc(1, 1, 3'b111, 2'd0, 13'h0000); // R2 deselected, close still proceeds
            chk("R5 ap timing", 64'(bank_open), (k < 4) ? 64'b0100 : 64'b0000);
        end

        cyc(0, 0, 3'b111, 2'd0, 13'h0000);
        chk("R7 pwr_down", 64'({pwr_down, self_ref}), 64'b10);
        cyc(0, 0, 3'b011, 2'd0, 13'h0000);
        chk("R7 op ignored", 64'(op), 64'd0);
        chk("R7 bank ignored", 64'(bank_open), 64'd0);
        cyc(1, 0, 3'b111, 2'd0, 13'h0000);
        chk("R7 exit", 64'({pwr_down, self_ref}), 64'b00);

        cyc(0, 0, 3'b001, 2'd0, 13'h0000);
        chk("R8 self_ref entry", 64'({pwr_down, self_ref}), 64'b01);
        chk("R8 op suppressed", 64'(op), 64'd0);
        cyc(0, 0, 3'b111, 2'd0, 13'h0000);
        chk("R8 self_ref hold", 64'({pwr_down, self_ref}), 64'b01);
        cyc(1, 0, 3'b111, 2'd0, 13'h0000);
        chk("R8 self_ref exit", 64'({pwr_down, self_ref}), 64'b00);

        cyc(1, 0, 3'b011, 2'd1, 13'h0055);
        cyc(0, 0, 3'b111, 2'd0, 13'h0000);
        chk("R11 pre-reset state", 64'({bank_open, pwr_down}), 64'b00101);
        rst_n = 1'b0;
        #2;
        chk("R11 async banks", 64'(bank_open), 64'd0);
        chk("R11 async lp", 64'({pwr_down, self_ref, op}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        summary();
    end
endmodule